// File: doc/BRIEF.md
# Endian-Aware Line Word Merge

This block folds a store into one 32-bit word of a cache line when the store hits. It takes the word currently held in the line, the store data, the access size, the two low bits of the store address, a byte-order flag and the index of the word within the line. It returns the word with the addressed lane replaced and the rest kept. It also raises a strobe naming which half of the line the store has dirtied.

The lane is found by XOR-ing the low address bits with a constant that is zero in little-endian mode and the largest lane of that access size in big-endian mode. The same address therefore reaches mirrored byte lanes in the two byte orders. The merge is purely combinational. The line storage sits outside the block and ORs the dirty strobes into its per-half flags, so once a flag is set it stays set until the line is cleaned.

Top module: `line_word_merge`

## Requirements
- R1: With accSize = 2 (word), mergedWord equals storeData in every bit, whatever addrLow and bigEndian are.
- R2: With accSize = 1 (halfword), the lane base byte is ({bigEndian,0} XOR {addrLow[1],0}), and bits base*8 up to base*8+15 of mergedWord equal storeData[15:0]. addrLow[0] has no effect.
- R3: With accSize = 0 (byte), the lane base byte is ({bigEndian,bigEndian} XOR addrLow), and bits base*8 up to base*8+7 of mergedWord equal storeData[7:0].
- R4: Every bit of mergedWord outside the written lane equals the same bit of curWord.
- R5: When wrEn is high, accSize is 0, 1 or 2, and wordIdx < LINE_WORDS/2, dirtyFirstSet is high and dirtyLastSet is low.
- R6: When wrEn is high, accSize is 0, 1 or 2, and wordIdx >= LINE_WORDS/2, dirtyLastSet is high and dirtyFirstSet is low.
- R7: When wrEn is low, both dirty strobes are low. mergedWord does not depend on wrEn.
- R8: With accSize = 3 (unsupported), mergedWord equals curWord and both dirty strobes are low.
- R9: The two dirty strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curWord | input | 32 | Word currently held in the line |
| storeData | input | 32 | Store data, right-aligned for byte and halfword accesses |
| accSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 unsupported |
| addrLow | input | 2 | Low two bits of the store address |
| bigEndian | input | 1 | High selects big-endian lane numbering |
| wordIdx | input | $clog2(LINE_WORDS) | Index of the word within the line |
| wrEn | input | 1 | Store hit qualifier that gates the dirty strobes |
| mergedWord | output | 32 | Word after the store is merged in |
| dirtyFirstSet | output | 1 | Set strobe for the first-half dirty flag |
| dirtyLastSet | output | 1 | Set strobe for the last-half dirty flag |

## Verification
The assertions are combinational and assume that every input carries a known 0 or 1 value at the moment they are evaluated. With an unknown accSize, for example, the lane-count checks have no defined meaning. The bench never leaves an input undriven. It holds all inputs at zero before the first vector, and it changes them only on a rising clock edge so that each vector is settled before it is sampled. The sweep covers every size code, address pair, byte order, word index and wrEn value, repeated over several data patterns, so each lane placement and each half of the line is reached in both byte orders.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  localparam int WORD_BITS  = 32;
  localparam int LANE_BITS  = 8;
  localparam int LANE_COUNT = WORD_BITS / LANE_BITS;
  localparam int LANE_SEL_W = $clog2(LANE_COUNT);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [LANE_COUNT-1:0] laneEn;
    logic [LANE_SEL_W-1:0] laneBase;
  } laneCtl_t;
endpackage

// File: rtl/lwm_lane_ctrl.sv
module lwm_lane_ctrl
  import lwm_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input  logic [1:0]       accSize,
  input  logic [1:0]       addrLow,
  input  logic             bigEndian,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             wrEn,
  output laneCtl_t         laneCtl,
  output logic             firstSet,
  output logic             lastSet
);
  localparam int HALF_WORDS = LINE_WORDS / 2;
  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(HALF_WORDS);

  logic sizeOk;
  logic inFirstHalf;
  logic [LANE_SEL_W-1:0] byteBase;
  logic [LANE_SEL_W-1:0] halfBase;

  assign byteBase = {bigEndian, bigEndian} ^ addrLow;
  assign halfBase = {bigEndian ^ addrLow[1], 1'b0};

  always_comb begin
    laneCtl = '0;
    sizeOk  = 1'b1;
    unique case (accSize_e'(accSize))
      SZ_BYTE: begin
        laneCtl.laneBase = byteBase;
        laneCtl.laneEn   = 4'b0001 << byteBase;
      end
      SZ_HALF: begin
        laneCtl.laneBase = halfBase;
        laneCtl.laneEn   = 4'b0011 << halfBase;
      end
      SZ_WORD: begin
        laneCtl.laneBase = '0;
        laneCtl.laneEn   = '1;
      end
      default: begin
        sizeOk = 1'b0;
      end
    endcase
  end

  assign inFirstHalf = (wordIdx < HALF_IDX);
  assign firstSet    = wrEn & sizeOk & inFirstHalf;
  assign lastSet     = wrEn & sizeOk & ~inFirstHalf;

  always_comb begin
    a_r9_strobes_exclusive: assert (!(firstSet && lastSet))
      else $error("both dirty strobes high");
    a_r7_idle_quiet: assert (wrEn || (!firstSet && !lastSet))
      else $error("dirty strobe without wrEn");
    a_r8_bad_size_inert: assert (accSize != 2'd3 || (laneCtl.laneEn == '0 && !firstSet && !lastSet))
      else $error("unsupported size touched the line");
    a_r2_half_aligned: assert (accSize != 2'd1 || laneCtl.laneEn == 4'b0011 || laneCtl.laneEn == 4'b1100)
      else $error("halfword lanes misaligned");
    a_r3_single_byte: assert (accSize != 2'd0 || $countones(laneCtl.laneEn) == 1)
      else $error("byte store enables wrong lane count");
  end
endmodule

// File: rtl/lwm_merge_dp.sv
module lwm_merge_dp
  import lwm_pkg::*;
(
  input  logic [WORD_BITS-1:0] curWord,
  input  logic [WORD_BITS-1:0] storeData,
  input  laneCtl_t             laneCtl,
  output logic [WORD_BITS-1:0] mergedWord
);
  for (genvar lane = 0; lane < LANE_COUNT; lane++) begin : g_lane
    localparam logic [LANE_SEL_W-1:0] LANE_ID = LANE_SEL_W'(lane);
    logic [LANE_SEL_W-1:0] srcLane;
    logic [LANE_BITS-1:0]  srcByte;
    logic [LANE_BITS-1:0]  oldByte;

    assign srcLane = LANE_ID - laneCtl.laneBase;
    assign srcByte = storeData[{srcLane, 3'b000} +: LANE_BITS];
    assign oldByte = curWord[lane*LANE_BITS +: LANE_BITS];
    assign mergedWord[lane*LANE_BITS +: LANE_BITS] =
      laneCtl.laneEn[lane] ? srcByte : oldByte;

    always_comb begin
      a_r4_lane_kept: assert (laneCtl.laneEn[lane] ||
                              mergedWord[lane*LANE_BITS +: LANE_BITS] == oldByte)
        else $error("unwritten lane %0d changed", lane);
    end
  end
endmodule

// File: rtl/line_word_merge.sv
module line_word_merge
  import lwm_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input  logic [31:0]      curWord,
  input  logic [31:0]      storeData,
  input  logic [1:0]       accSize,
  input  logic [1:0]       addrLow,
  input  logic             bigEndian,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             wrEn,
  output logic [31:0]      mergedWord,
  output logic             dirtyFirstSet,
  output logic             dirtyLastSet
);
  laneCtl_t laneCtl;

  lwm_lane_ctrl #(.LINE_WORDS(LINE_WORDS)) ctrl_i (
    .accSize  (accSize),
    .addrLow  (addrLow),
    .bigEndian(bigEndian),
    .wordIdx  (wordIdx),
    .wrEn     (wrEn),
    .laneCtl  (laneCtl),
    .firstSet (dirtyFirstSet),
    .lastSet  (dirtyLastSet)
  );

  lwm_merge_dp dp_i (
    .curWord   (curWord),
    .storeData (storeData),
    .laneCtl   (laneCtl),
    .mergedWord(mergedWord)
  );
endmodule

// File: tb/line_word_merge_tb.sv
module line_word_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_WORDS = 8;
  localparam int IDX_W = $clog2(LINE_WORDS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] curWord, storeData, mergedWord;
  logic [1:0] accSize, addrLow;
  logic bigEndian, wrEn, dirtyFirstSet, dirtyLastSet;
  logic [IDX_W-1:0] wordIdx;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_word_merge #(.LINE_WORDS(LINE_WORDS)) dut_i (
    .curWord(curWord), .storeData(storeData), .accSize(accSize),
    .addrLow(addrLow), .bigEndian(bigEndian), .wordIdx(wordIdx),
    .wrEn(wrEn), .mergedWord(mergedWord),
    .dirtyFirstSet(dirtyFirstSet), .dirtyLastSet(dirtyLastSet)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int p);
    case (p)
      0: return 32'hA5C3_0F96;
      1: return 32'h1234_5678;
      default: return 32'hFFFF_0000;
    endcase
  endfunction

  initial begin
    curWord = '0; storeData = '0; accSize = '0; addrLow = '0;
    bigEndian = 1'b0; wrEn = 1'b0; wordIdx = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset strobes", {30'd0, dirtyFirstSet, dirtyLastSet}, 32'd0);
    check("R4 reset word", mergedWord, 32'd0);
    rstN = 1'b1;
    for (int p = 0; p < 3; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int a = 0; a < 4; a++) begin
          for (int be = 0; be < 2; be++) begin
            for (int we = 0; we < 2; we++) begin
              for (int ix = 0; ix < LINE_WORDS; ix++) begin
                logic [31:0] cw, sd, mask, expWord;
                int off;
                bit firstExp, lastExp;
                cw = pattern(p);
                sd = ~pattern((p + 1) % 3) ^ 32'h3C3C_5A5A;
                @(posedge clk);
                curWord = cw; storeData = sd; accSize = 2'(sz);
                addrLow = 2'(a); bigEndian = be[0]; wrEn = we[0];
                wordIdx = IDX_W'(ix);
                @(negedge clk);
                case (sz)
                  0: begin off = (be * 3) ^ a; mask = 32'hFF << (off * 8); end
                  1: begin off = (be * 2) ^ (a & 2); mask = 32'hFFFF << (off * 8); end
                  2: begin off = 0; mask = 32'hFFFF_FFFF; end
                  default: begin off = 0; mask = 32'h0; end
                endcase
                expWord = (cw & ~mask) | ((sd << (off * 8)) & mask);
                if (sz == 2) check("R1 word", mergedWord, sd);
                else if (sz == 1) check("R2 half lane", mergedWord & mask, expWord & mask);
                else if (sz == 0) check("R3 byte lane", mergedWord & mask, expWord & mask);
                else check("R8 word unchanged", mergedWord, cw);
                check("R4 outside lane", mergedWord & ~mask, cw & ~mask);
                firstExp = (we == 1) && (sz != 3) && (ix < LINE_WORDS / 2);
                lastExp  = (we == 1) && (sz != 3) && (ix >= LINE_WORDS / 2);
                if (we == 0) check("R7 idle strobes", {30'd0, dirtyFirstSet, dirtyLastSet}, 32'd0);
                else if (sz == 3) check("R8 no strobe", {30'd0, dirtyFirstSet, dirtyLastSet}, 32'd0);
                else if (ix < LINE_WORDS / 2) check("R5 first half", {30'd0, dirtyFirstSet, dirtyLastSet}, {30'd0, firstExp, lastExp});
                else check("R6 last half", {30'd0, dirtyFirstSet, dirtyLastSet}, {30'd0, firstExp, lastExp});
                check("R9 exclusive", {31'd0, dirtyFirstSet & dirtyLastSet}, 32'd0);
              end
            end
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule